// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block starts and halts the virtual processors (VPs) of one cluster for software. Software writes a one-bit-per-VP mask to a start register or a halt register and reads back a status vector of which VPs are running. The same three registers can be reached through two address windows with identical behaviour. One window serves the local cluster and the other serves remote cores.

Starting a VP takes effect only when the VP confirms it. A start command raises a per-VP start request, and that request stays high until the VP acknowledges it. Only then does the VP's status bit go high. Halting takes effect at once: each running VP named in the command gets a one-cycle halt pulse, and its status bit clears on the same clock edge.

After reset every status bit is clear. Start requests are then raised for the VPs chosen by a start-up parameter.

Top module: `vp_runstop_ctrl`

## Requirements
- R1: Command data is masked to the low NUM_VP bits. Write data bits at or above NUM_VP have no effect on any output.
- R2: A write to the start register (window offset 0x00) raises `vp_start_req` from the next edge for each selected VP that is neither running nor already requesting. Selected VPs that are already running or already requesting are unchanged.
- R3: A write to the halt register (window offset 0x08) pulses `vp_halt` high for exactly one cycle, and clears `vp_running`, on the same edge for each selected VP that is running. Selected VPs that are not running get no pulse.
- R4: `vp_ack` on a VP that has a pending request sets its `vp_running` bit and drops its request at the next edge. `vp_ack` on a VP with no pending request is ignored.
- R5: Window 0 (`bus_addr[11:9]` = 0) and window 1 (`bus_addr[11:9]` = 1) decode the same three offsets with identical effect.
- R6: While `rst` is high and at the first cycle after it: `vp_running` = 0, `vp_halt` = 0, `bus_rdata` = 0, and `vp_start_req` equals START_RUNNING.
- R7: A read of the status register (window offset 0x10) returns the zero-extended `vp_running` in `bus_rdata` one cycle later. Any other read returns 0, and writes to unmapped offsets or windows change nothing.
- R8: A halt command that meets an acknowledge for the same VP in the same cycle wins. That VP ends with no request, no running bit, and a one-cycle halt pulse.
- R9: A start request stays high until the VP acknowledges it or is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: window select and offset |
| bus_wdata | input | DATA_W | Write data, one bit per VP |
| bus_rdata | output | DATA_W | Registered read data |
| vp_ack | input | NUM_VP | Per-VP acknowledge of a start request |
| vp_start_req | output | NUM_VP | Per-VP start request, held until acknowledged |
| vp_halt | output | NUM_VP | Per-VP one-cycle halt pulse |
| vp_running | output | NUM_VP | Running status vector |

## Verification
Each command and each acknowledge that the design captures at a rising edge shows its effect on `vp_start_req`, `vp_halt` and `vp_running` right after that same edge. The bench samples these outputs at the following falling edge. Read data is due one edge after the read is captured. The driver queues the expected word for each read, and a monitor samples the read strobe at the capturing edge, then checks `bus_rdata` 2 ns later. The halt pulse is also checked one cycle further on to confirm that it has ended.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_START  = 2'd1,
    SEL_HALT   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_t;

  localparam int unsigned OFS_START  = 'h00;
  localparam int unsigned OFS_HALT   = 'h08;
  localparam int unsigned OFS_STATUS = 'h10;
  localparam int unsigned NUM_WINDOWS = 2;
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
  import vpc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WIN_BIT = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam int WSEL_W = ADDR_W - WIN_BIT;

  logic [WSEL_W-1:0]  win;
  logic [WIN_BIT-1:0] ofs;
  logic               win_hit;

  assign win     = addr[ADDR_W-1:WIN_BIT];
  assign ofs     = addr[WIN_BIT-1:0];
  assign win_hit = (int'(win) < NUM_WINDOWS);

  always_comb begin
    sel = SEL_NONE;
    if (win_hit) begin
      if (ofs == WIN_BIT'(OFS_START))       sel = SEL_START;
      else if (ofs == WIN_BIT'(OFS_HALT))   sel = SEL_HALT;
      else if (ofs == WIN_BIT'(OFS_STATUS)) sel = SEL_STATUS;
    end
  end
endmodule

// File: rtl/vpc_slot.sv
module vpc_slot #(
  parameter bit START_ON = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start_cmd,
  input  logic stop_cmd,
  input  logic ack,
  output logic running,
  output logic pend,
  output logic halt
);
  logic ack_take;
  logic stop_take;
  logic start_take;

  assign ack_take   = pend & ack;
  assign stop_take  = stop_cmd & (running | ack_take);
  assign start_take = start_cmd & ~running & ~pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pend    <= START_ON;
      halt    <= 1'b0;
    end else begin
      halt <= stop_take;
      if (stop_take) begin
        running <= 1'b0;
        pend    <= 1'b0;
      end else if (ack_take) begin
        running <= 1'b1;
        pend    <= 1'b0;
      end else if (start_take) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vp_runstop_ctrl.sv
module vp_runstop_ctrl
  import vpc_pkg::*;
#(
  parameter int              NUM_VP        = 1,
  parameter int              DATA_W        = 64,
  parameter int              ADDR_W        = 12,
  parameter int              WIN_BIT       = 9,
  parameter logic [DATA_W-1:0] START_RUNNING = 'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_VP-1:0] vp_ack,
  output logic [NUM_VP-1:0] vp_start_req,
  output logic [NUM_VP-1:0] vp_halt,
  output logic [NUM_VP-1:0] vp_running
);
  function automatic logic [DATA_W-1:0] build_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < NUM_VP);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] VP_MASK = build_mask();

  if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_count
    $error("vp_runstop_ctrl: NUM_VP must lie in 1..DATA_W");
  end
  if (START_RUNNING > VP_MASK) begin : g_bad_start
    $error("vp_runstop_ctrl: START_RUNNING selects VPs beyond NUM_VP");
  end

  reg_sel_t          sel;
  logic [DATA_W-1:0] cmd_data;
  logic [NUM_VP-1:0] start_vec;
  logic [NUM_VP-1:0] stop_vec;
  logic              wr_fire;

  vpc_decode #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_fire   = bus_valid & bus_write;
  assign cmd_data  = bus_wdata & VP_MASK;
  assign start_vec = (wr_fire && sel == SEL_START) ? cmd_data[NUM_VP-1:0] : '0;
  assign stop_vec  = (wr_fire && sel == SEL_HALT)  ? cmd_data[NUM_VP-1:0] : '0;

  for (genvar i = 0; i < NUM_VP; i++) begin : g_slot
    vpc_slot #(.START_ON(START_RUNNING[i])) u_slot (
      .clk       (clk),
      .rst       (rst),
      .start_cmd (start_vec[i]),
      .stop_cmd  (stop_vec[i]),
      .ack       (vp_ack[i]),
      .running   (vp_running[i]),
      .pend      (vp_start_req[i]),
      .halt      (vp_halt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_valid && !bus_write && sel == SEL_STATUS) begin
      bus_rdata <= DATA_W'(vp_running);
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int NUM_VP = 1,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_VP-1:0] vp_ack,
  input logic [NUM_VP-1:0] vp_start_req,
  input logic [NUM_VP-1:0] vp_halt,
  input logic [NUM_VP-1:0] vp_running
);
  assert_halted_not_running_R3: assert property (@(posedge clk) disable iff (rst)
    (vp_halt & vp_running) == '0);

  assert_halt_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    (vp_halt & ~$past(vp_running | (vp_start_req & vp_ack))) == '0);

  assert_run_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (vp_running & ~$past(vp_running) & ~$past(vp_start_req & vp_ack)) == '0);

  assert_req_excl_running_R9: assert property (@(posedge clk) disable iff (rst)
    (vp_start_req & vp_running) == '0);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(vp_start_req) & ~$past(vp_ack) & ~vp_start_req) & ~vp_halt) == '0);

  assert_rdata_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid && !bus_write) |-> bus_rdata == '0);
endmodule

bind vp_runstop_ctrl vpc_checker #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_vpc_checker (
  .clk          (clk),
  .rst          (rst),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_rdata    (bus_rdata),
  .vp_ack       (vp_ack),
  .vp_start_req (vp_start_req),
  .vp_halt      (vp_halt),
  .vp_running   (vp_running)
);

// File: tb/vp_runstop_ctrl_bench.sv
`timescale 1ns/1ps
module vp_runstop_ctrl_bench;
  localparam int NV = 4;
  localparam int DW = 64;
  localparam int AW = 12;
  localparam logic [AW-1:0] W0 = 12'h000;
  localparam logic [AW-1:0] W1 = 12'h200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NV-1:0] vp_ack = '0;
  logic [NV-1:0] vp_start_req, vp_halt, vp_running;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  vp_runstop_ctrl #(.NUM_VP(NV), .DATA_W(DW), .ADDR_W(AW), .WIN_BIT(9),
                    .START_RUNNING(64'h5)) u_vp_runstop_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vp_ack(vp_ack), .vp_start_req(vp_start_req), .vp_halt(vp_halt),
    .vp_running(vp_running));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_vp(string req, logic [NV-1:0] run, logic [NV-1:0] pend,
                          logic [NV-1:0] halt);
    check({req, " running"}, DW'(vp_running), DW'(run));
    check({req, " start_req"}, DW'(vp_start_req), DW'(pend));
    check({req, " halt"}, DW'(vp_halt), DW'(halt));
  endtask

  // One access; returns at the falling edge after the capturing rising edge.
  task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [NV-1:0] ack = '0);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; vp_ack = ack;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; vp_ack = '0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic ack_only(logic [NV-1:0] ack);
    vp_ack = ack;
    @(negedge clk);
    vp_ack = '0;
  endtask

  // Monitor: read strobe seen at the edge, data checked 2 ns later.
  always @(posedge clk) begin
    automatic bit rd = bus_valid && !bus_write && !rst;
    #2;
    if (rd) begin
      if (exp_q.size() == 0) check("R7 queue", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check_vp("R6 in reset", 4'b0000, 4'b0101, 4'b0000);
    check("R6 rdata", bus_rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    check_vp("R6 after reset", 4'b0000, 4'b0101, 4'b0000);

    ack_only(4'b0001);
    check_vp("R4 ack vp0", 4'b0001, 4'b0100, 4'b0000);
    ack_only(4'b0010);
    check_vp("R4 stray ack ignored", 4'b0001, 4'b0100, 4'b0000);
    bus_rd(W0 + 12'h10, 64'h1, "R7 status window0");

    bus_wr(W1 + 12'h00, 64'hFFFF_FFFF_FFFF_FFFA);
    check_vp("R1 R5 start window1 masked", 4'b0001, 4'b1110, 4'b0000);
    bus_wr(W0 + 12'h00, 64'hF);
    check_vp("R2 no duplicate, running kept", 4'b0001, 4'b1110, 4'b0000);
    @(negedge clk); @(negedge clk);
    check_vp("R9 requests held", 4'b0001, 4'b1110, 4'b0000);

    ack_only(4'b1110);
    check_vp("R4 ack all", 4'b1111, 4'b0000, 4'b0000);

    bus_wr(W1 + 12'h08, 64'hFFFF_FFFF_FFFF_FFF3);
    check_vp("R3 R5 halt window1", 4'b1100, 4'b0000, 4'b0011);
    @(negedge clk);
    check_vp("R3 halt one cycle", 4'b1100, 4'b0000, 4'b0000);
    bus_wr(W0 + 12'h08, 64'h3);
    check_vp("R3 halt on stopped vp", 4'b1100, 4'b0000, 4'b0000);

    bus_wr(W0 + 12'h00, 64'h1);
    check_vp("R2 start vp0", 4'b1100, 4'b0001, 4'b0000);
    bus_wr(W0 + 12'h08, 64'h1, 4'b0001);
    check_vp("R8 halt beats ack", 4'b1100, 4'b0000, 4'b0001);
    @(negedge clk);
    check_vp("R8 settled", 4'b1100, 4'b0000, 4'b0000);

    bus_rd(W1 + 12'h10, 64'hC, "R5 status window1");
    bus_rd(W0 + 12'h18, 64'h0, "R7 unmapped offset");
    bus_rd(12'h400 + 12'h10, 64'h0, "R7 outside windows");
    bus_rd(W0 + 12'h00, 64'h0, "R7 command register reads zero");
    bus_wr(W0 + 12'h20, 64'hF);
    check_vp("R7 unmapped write", 4'b1100, 4'b0000, 4'b0000);
    bus_wr(12'h400, 64'hF);
    check_vp("R7 out-of-window write", 4'b1100, 4'b0000, 4'b0000);
    bus_wr(W0 + 12'h08, 64'hFFFF_FFFF_FFFF_FFF0);
    check_vp("R1 halt high bits ignored", 4'b1100, 4'b0000, 4'b0000);
    bus_rd(W0 + 12'h10, 64'hC, "R7 status final");
    @(negedge clk); @(negedge clk);
    if (exp_q.size() != 0) check("R7 reads drained", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule